// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block resolves read-after-write hazards for the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it produces a two-bit select code. The code tells the operand multiplexer whether to take the value the register file returned in decode, the ALU result still held in the execute/memory pipeline register, or the value that the memory/writeback register is writing back. A match needs the producer's write enable, a nonzero destination register, and a destination equal to the operand's source register. When both producers match, the more recent one, in the execute/memory register, wins.

The block also contains the architectural register file. Its two combinational read ports, used by decode, see a writeback aimed at the same register in the same cycle. The new value is returned straight away, so the write-then-read case needs no third forwarding path. Register 0 is hard-wired to zero. It is never written and never forwarded.

Top module: `exec_fwd_unit`

## Requirements
- R1: An operand's select is 2'b10 (execute/memory result) when `exm_we_i` is 1, `exm_rd_i` is nonzero and the operand's source register equals `exm_rd_i`.
- R2: An operand's select is 2'b01 (writeback value) when `wb_we_i` is 1, `wb_rd_i` is nonzero, the source register equals `wb_rd_i` and R1 does not apply.
- R3: When both the execute/memory and the writeback producers match the same operand, the select is 2'b10.
- R4: A source register of 0 always yields select 2'b00 (register file), even if a producer names register 0 with its write enable set.
- R5: A producer whose write enable is 0 never causes forwarding. With no qualifying match the select is 2'b00.
- R6: Operands A and B are decided independently. Each can take a different source in the same cycle.
- R7: When `wb_we_i` is 1 and `wb_rd_i` is nonzero and equal to a read address, that read port returns `wb_data_i` in the same cycle.
- R8: Read address 0 always returns zero. A writeback to register 0 changes no register.
- R9: A register written at a rising clock edge returns the written value on later reads. After reset every register reads zero.
- R10: The select code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the register file |
| rd_addr_a_i | input | AW | Decode-stage read address, port A |
| rd_addr_b_i | input | AW | Decode-stage read address, port B |
| rd_data_a_o | output | XLEN | Read data port A, with write-through |
| rd_data_b_o | output | XLEN | Read data port B, with write-through |
| idex_rs_a_i | input | AW | Source register of operand A in the execute stage |
| idex_rs_b_i | input | AW | Source register of operand B in the execute stage |
| exm_we_i | input | 1 | Register write enable of the instruction in the memory stage |
| exm_rd_i | input | AW | Destination register of the instruction in the memory stage |
| wb_we_i | input | 1 | Writeback enable, also the register file write enable |
| wb_rd_i | input | AW | Writeback destination register |
| wb_data_i | input | XLEN | Writeback data |
| fwd_sel_a_o | output | 2 | Operand A source: 00 regfile, 01 writeback, 10 exe/mem |
| fwd_sel_b_o | output | 2 | Operand B source: 00 regfile, 01 writeback, 10 exe/mem |

## Verification
The bench uses the default parameters: 32 registers of 32 bits, which gives 5-bit register tags. With these values the highest register index, 31, can be used both as a forwarding tag and as a storage location, and every all-ones address is exercised. The tag patterns include the zero register named by producers with their write enables set, and both producers colliding on one operand. They also include crossed matches, where A takes one producer and B takes the other.

// File: rtl/exec_fwd_pkg.sv
package exec_fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/exec_fwd_match.sv
module exec_fwd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          we_i,
  output logic          hit_o
);
  always_comb hit_o = we_i && (dst_i != '0) && (src_i == dst_i);
endmodule

// File: rtl/exec_fwd_operand.sv
module exec_fwd_operand
  import exec_fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_rd_i,
  output fwd_sel_e      sel_o
);
  logic exm_hit, wb_hit;

  exec_fwd_match #(.AW(AW)) u_exm (.src_i(rs_i), .dst_i(exm_rd_i), .we_i(exm_we_i), .hit_o(exm_hit));
  exec_fwd_match #(.AW(AW)) u_wb  (.src_i(rs_i), .dst_i(wb_rd_i),  .we_i(wb_we_i),  .hit_o(wb_hit));

  // nearest producer first
  always_comb begin
    if (exm_hit)     sel_o = SEL_EXM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/exec_regfile_wt.sv
module exec_regfile_wt #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [XLEN-1:0]          wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] regs_q [NREGS];
  logic            wr_ok;

  always_comb wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_ok) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr_i[p] == '0)                      rdata_o[p] = '0;
      else if (wr_ok && (waddr_i == raddr_i[p])) rdata_o[p] = wdata_i;
      else                                       rdata_o[p] = regs_q[raddr_i[p]];
    end
  end
endmodule

// File: rtl/exec_fwd_unit.sv
module exec_fwd_unit
  import exec_fwd_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   rd_addr_a_i,
  input  logic [AW-1:0]   rd_addr_b_i,
  output logic [XLEN-1:0] rd_data_a_o,
  output logic [XLEN-1:0] rd_data_b_o,
  input  logic [AW-1:0]   idex_rs_a_i,
  input  logic [AW-1:0]   idex_rs_b_i,
  input  logic            exm_we_i,
  input  logic [AW-1:0]   exm_rd_i,
  input  logic            wb_we_i,
  input  logic [AW-1:0]   wb_rd_i,
  input  logic [XLEN-1:0] wb_data_i,
  output logic [1:0]      fwd_sel_a_o,
  output logic [1:0]      fwd_sel_b_o
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][AW-1:0]   rs;
  fwd_sel_e                  sel [NOPS];
  logic [NOPS-1:0][AW-1:0]   raddr;
  logic [NOPS-1:0][XLEN-1:0] rdata;

  always_comb begin
    rs[0]    = idex_rs_a_i;
    rs[1]    = idex_rs_b_i;
    raddr[0] = rd_addr_a_i;
    raddr[1] = rd_addr_b_i;
  end

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    exec_fwd_operand #(.AW(AW)) u_op (
      .rs_i     (rs[o]),
      .exm_we_i (exm_we_i),
      .exm_rd_i (exm_rd_i),
      .wb_we_i  (wb_we_i),
      .wb_rd_i  (wb_rd_i),
      .sel_o    (sel[o])
    );
  end

  exec_regfile_wt #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NOPS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_we_i),
    .waddr_i (wb_rd_i),
    .wdata_i (wb_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  always_comb begin
    fwd_sel_a_o = sel[0];
    fwd_sel_b_o = sel[1];
    rd_data_a_o = rdata[0];
    rd_data_b_o = rdata[1];
  end
endmodule

// File: rtl/exec_fwd_checker.sv
module exec_fwd_checker #(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   rd_addr_a_i,
  input logic [XLEN-1:0] rd_data_a_o,
  input logic [AW-1:0]   idex_rs_a_i,
  input logic [AW-1:0]   idex_rs_b_i,
  input logic            exm_we_i,
  input logic [AW-1:0]   exm_rd_i,
  input logic            wb_we_i,
  input logic [AW-1:0]   wb_rd_i,
  input logic [XLEN-1:0] wb_data_i,
  input logic [1:0]      fwd_sel_a_o,
  input logic [1:0]      fwd_sel_b_o
);
  a_r10_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_a_o != 2'b11) && (fwd_sel_b_o != 2'b11));

  a_r4_zero_src_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_rs_a_i == '0) |-> (fwd_sel_a_o == 2'b00));

  a_r4_zero_src_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_rs_b_i == '0) |-> (fwd_sel_b_o == 2'b00));

  a_r3_exm_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exm_we_i && wb_we_i && exm_rd_i == wb_rd_i && idex_rs_a_i == exm_rd_i && exm_rd_i != '0)
      |-> (fwd_sel_a_o == 2'b10));

  a_r5_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exm_we_i && !wb_we_i) |-> (fwd_sel_a_o == 2'b00 && fwd_sel_b_o == 2'b00));

  a_r8_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> (rd_data_a_o == '0));

  a_r9_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wb_we_i) && $past(wb_rd_i) != '0 && rd_addr_a_i == $past(wb_rd_i)
     && !(wb_we_i && wb_rd_i == rd_addr_a_i))
      |-> (rd_data_a_o == $past(wb_data_i)));
endmodule

bind exec_fwd_unit exec_fwd_checker #(.AW(AW), .XLEN(XLEN)) u_fwd_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
  .idex_rs_a_i(idex_rs_a_i), .idex_rs_b_i(idex_rs_b_i), .exm_we_i(exm_we_i),
  .exm_rd_i(exm_rd_i), .wb_we_i(wb_we_i), .wb_rd_i(wb_rd_i), .wb_data_i(wb_data_i),
  .fwd_sel_a_o(fwd_sel_a_o), .fwd_sel_b_o(fwd_sel_b_o)
);

// File: tb/exec_fwd_unit_tb_top.sv
`timescale 1ns/1ps
module exec_fwd_unit_tb_top;
  localparam int NREGS = 32;
  localparam int XLEN  = 32;
  localparam int AW    = 5;
  localparam int NVEC  = 12;
  // {rs_a, rs_b, exm_we, exm_rd, wb_we, wb_rd, exp_a, exp_b}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00},  // R1
    {5'd4,  5'd3,  1'b1, 5'd3,  1'b0, 5'd0,  2'b00, 2'b10},  // R1
    {5'd7,  5'd7,  1'b0, 5'd7,  1'b1, 5'd7,  2'b01, 2'b01},  // R2
    {5'd5,  5'd6,  1'b1, 5'd5,  1'b1, 5'd5,  2'b10, 2'b00},  // R3
    {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},  // R4
    {5'd9,  5'd2,  1'b0, 5'd9,  1'b0, 5'd2,  2'b00, 2'b00},  // R5
    {5'd9,  5'd2,  1'b1, 5'd2,  1'b1, 5'd9,  2'b01, 2'b10},  // R6
    {5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 2'b10, 2'b10},  // R1
    {5'd12, 5'd13, 1'b1, 5'd14, 1'b1, 5'd15, 2'b00, 2'b00},  // R5
    {5'd8,  5'd8,  1'b1, 5'd8,  1'b1, 5'd8,  2'b10, 2'b10},  // R3
    {5'd1,  5'd2,  1'b0, 5'd1,  1'b1, 5'd2,  2'b00, 2'b01},  // R2
    {5'd0,  5'd5,  1'b1, 5'd0,  1'b1, 5'd5,  2'b00, 2'b01}   // R4
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [AW-1:0]   rd_addr_a_i = '0, rd_addr_b_i = '0;
  logic [XLEN-1:0] rd_data_a_o, rd_data_b_o;
  logic [AW-1:0]   idex_rs_a_i = '0, idex_rs_b_i = '0;
  logic            exm_we_i = 1'b0, wb_we_i = 1'b0;
  logic [AW-1:0]   exm_rd_i = '0, wb_rd_i = '0;
  logic [XLEN-1:0] wb_data_i = '0;
  logic [1:0]      fwd_sel_a_o, fwd_sel_b_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  exec_fwd_unit #(.NREGS(NREGS), .XLEN(XLEN)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    exm_we_i = 0; wb_we_i = 0; exm_rd_i = '0; wb_rd_i = '0; wb_data_i = '0;
    idex_rs_a_i = '0; idex_rs_b_i = '0; rd_addr_a_i = '0; rd_addr_b_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); idle(); rst_ni = 0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1;
  endtask

  initial begin
    do_reset();
    // reset state
    rd_addr_a_i = 5'd5; rd_addr_b_i = 5'd31; #1;
    chk("R9 reset rd_a", rd_data_a_o, 0);
    chk("R9 reset rd_b", rd_data_b_o, 0);
    chk("R5 reset sel_a", {30'b0, fwd_sel_a_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      {idex_rs_a_i, idex_rs_b_i, exm_we_i, exm_rd_i, wb_we_i, wb_rd_i} = VEC[i][25:4];
      #1;
      chk($sformatf("R1/R2/R3/R4/R5/R6/R10 vec%0d sel_a", i), {30'b0, fwd_sel_a_o}, {30'b0, VEC[i][3:2]});
      chk($sformatf("R1/R2/R3/R4/R5/R6/R10 vec%0d sel_b", i), {30'b0, fwd_sel_b_o}, {30'b0, VEC[i][1:0]});
    end

    do_reset();
    // R7 write-through
    wb_we_i = 1; wb_rd_i = 5'd5; wb_data_i = 32'hA5A5_0001;
    rd_addr_a_i = 5'd5; rd_addr_b_i = 5'd6; #1;
    chk("R7 write-through rd_a", rd_data_a_o, 32'hA5A5_0001);
    chk("R7 other port unaffected", rd_data_b_o, 0);
    @(negedge clk_i);
    wb_we_i = 0; wb_data_i = 32'h0; rd_addr_b_i = 5'd5; #1;
    chk("R9 stored rd_a", rd_data_a_o, 32'hA5A5_0001);
    chk("R9 stored rd_b", rd_data_b_o, 32'hA5A5_0001);
    // R8 write to register 0
    wb_we_i = 1; wb_rd_i = 5'd0; wb_data_i = 32'hFFFF_FFFF; rd_addr_a_i = 5'd0; #1;
    chk("R8 r0 same cycle", rd_data_a_o, 0);
    chk("R8 r5 unchanged", rd_data_b_o, 32'hA5A5_0001);
    @(negedge clk_i);
    wb_we_i = 0; #1;
    chk("R8 r0 after write", rd_data_a_o, 0);
    chk("R8 r5 after r0 write", rd_data_b_o, 32'hA5A5_0001);
    // top register
    wb_we_i = 1; wb_rd_i = 5'd31; wb_data_i = 32'h1234_5678; rd_addr_a_i = 5'd31;
    @(negedge clk_i);
    wb_we_i = 0; wb_data_i = 32'hDEAD_BEEF; #1;
    chk("R9 r31 stored", rd_data_a_o, 32'h1234_5678);
    // write-through beats stale storage
    wb_we_i = 1; wb_rd_i = 5'd31; wb_data_i = 32'h0BAD_F00D; #1;
    chk("R7 overwrite same cycle", rd_data_a_o, 32'h0BAD_F00D);
    @(negedge clk_i);
    wb_we_i = 0;
    do_reset();
    rd_addr_a_i = 5'd31; rd_addr_b_i = 5'd5; #1;
    chk("R9 cleared r31", rd_data_a_o, 0);
    chk("R9 cleared r5", rd_data_b_o, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule